// File: doc/BRIEF.md
# Lane Swizzle Permutation Unit

This block reorders data across 32 lanes of 32 bits each. Each command carries a 3-bit mode and a 16-bit pattern word. For every output lane the block works out which input lane feeds it and drives that lane's value through a crossbar. The result is captured in an output register and marked with a valid strobe. A vector unit uses it to exchange values between threads without a trip through memory. There are five lane-exchange modes and one pass-through mode. Every mode computes the source lane id from the destination lane id with small bitwise arithmetic.

Four of the exchanges reduce to a single form, `src = ((id & A) | O) ^ X`: bitmask permute, group broadcast, neighbour swap and group reverse. Quad permute instead takes the two low id bits from a selector table. The decoder checks the parameters of each command. A command with an illegal size, an out-of-range broadcast index or an unknown mode raises an error flag, and its lanes leave the block unchanged.

Top module: `lsw_unit`

## Requirements
- R1: While reset is held, and after it until the first command, out_valid is 0, out_err is 0 and all of out_lanes is 0.
- R2: A command sampled with in_valid high at a clock edge appears on out_lanes/out_err at that same edge. out_valid is high exactly in the cycle after each cycle with in_valid high, so back-to-back commands each give one result.
- R3: In a cycle with in_valid low, out_lanes and out_err keep their previous values whatever the other inputs do.
- R4: Mode 0 (pass) copies every input lane to the same output lane. The pattern word is ignored.
- R5: Mode 1 (quad permute) reads selectors from pat[1:0], pat[3:2], pat[5:4] and pat[7:6] for positions 0 to 3. Output lane 4q+k takes input lane 4q+sel_k.
- R6: Mode 2 (bitmask) reads one 2-bit code per lane id bit b from pat[2b+1:2b]. The codes are 0 (force 0), 1 (force 1), 2 (keep) and 3 (invert). Output lane i takes the input lane whose id is i transformed bit by bit.
- R7: Mode 3 (broadcast) reads the group size from pat[5:0] (2, 4, 8, 16 or 32) and the index from pat[12:8]. Every lane takes the indexed lane of its own aligned group.
- R8: Mode 4 (swap) reads a size from pat[5:0] (1, 2, 4, 8 or 16). Each aligned block of 2×size lanes exchanges its lower and upper halves.
- R9: Mode 5 (reverse) reads the group size from pat[5:0] (2, 4, 8, 16 or 32). Lane order is mirrored inside each aligned group.
- R10: Any of the following sets out_err to 1 and copies in_lanes to out_lanes unchanged: a size outside the set allowed for its mode, a broadcast index not below the group size, or a mode of 6 or 7. Every legal command sets out_err to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command and lanes are valid this cycle |
| in_mode | input | 3 | Exchange mode (0 pass, 1 quad, 2 bitmask, 3 broadcast, 4 swap, 5 reverse) |
| in_pat | input | 16 | Mode parameters |
| in_lanes | input | 1024 | Input lanes, lane i at bits [32i+31:32i] |
| out_valid | output | 1 | Result registered in the previous cycle is present |
| out_lanes | output | 1024 | Permuted lanes, same packing as in_lanes |
| out_err | output | 1 | Last command was illegal and was passed through |

## Verification
A wrong source index in one lane's generator would put a foreign value in that lane on the first result of an affected mode. One cycle after the command it is visible as a single mismatched 32-bit slice. A decoder that misjudges legality shows on the same cycle in two ways: out_err is wrong, and the permutation is applied where a pass-through was owed, or the reverse. A broken load enable breaks the output hold. It shows the cycle after a quiet cycle, as out_lanes that moved with in_valid low.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  localparam int unsigned LSW_LANES = 32;
  localparam int unsigned LSW_IDW   = $clog2(LSW_LANES);
  localparam int unsigned LSW_PATW  = 16;

  typedef enum logic [2:0] {
    MD_PASS    = 3'd0,
    MD_QUAD    = 3'd1,
    MD_BITMASK = 3'd2,
    MD_BCAST   = 3'd3,
    MD_SWAP    = 3'd4,
    MD_REVERSE = 3'd5
  } lsw_mode_e;

  typedef struct packed {
    logic                   quad;
    logic [3:0][1:0]        qsel;
    logic [LSW_IDW-1:0]     and_m;
    logic [LSW_IDW-1:0]     or_m;
    logic [LSW_IDW-1:0]     xor_m;
    logic                   err;
  } lsw_ctl_t;

  // Size is a power of two within [lo, hi].
  function automatic logic lsw_size_ok(input logic [LSW_IDW:0] size,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return ($countones(size) == 1) && (int'(size) >= lo) && (int'(size) <= hi);
  endfunction

  // Source lane id for destination lane id under a decoded control word.
  function automatic logic [LSW_IDW-1:0] lsw_lane_src(input lsw_ctl_t c,
                                                      input logic [LSW_IDW-1:0] id);
    logic [LSW_IDW-1:0] s;
    if (c.quad) begin
      s = id;
      s[1:0] = c.qsel[id[1:0]];
    end else begin
      s = ((id & c.and_m) | c.or_m) ^ c.xor_m;
    end
    return s;
  endfunction

endpackage

// File: rtl/lsw_decode.sv
module lsw_decode
  import lsw_pkg::*;
(
  input  logic [2:0]          mode,
  input  logic [LSW_PATW-1:0] pat,
  output lsw_ctl_t            ctl
);

  logic [LSW_IDW:0]   size;
  logic [LSW_IDW-1:0] size_m1;
  logic [LSW_IDW-1:0] bidx;

  assign size    = pat[LSW_IDW:0];
  assign size_m1 = LSW_IDW'(size - 1'b1);
  assign bidx    = pat[8 +: LSW_IDW];

  always_comb begin
    ctl       = '0;
    ctl.and_m = '1;
    unique case (mode)
      MD_PASS: ;
      MD_QUAD: begin
        ctl.quad = 1'b1;
        ctl.qsel = pat[7:0];
      end
      MD_BITMASK: begin
        for (int b = 0; b < LSW_IDW; b++) begin
          unique case (pat[2*b +: 2])
            2'd0: ctl.and_m[b] = 1'b0;
            2'd1: begin
              ctl.and_m[b] = 1'b0;
              ctl.or_m[b]  = 1'b1;
            end
            2'd2: ;
            default: ctl.xor_m[b] = 1'b1;
          endcase
        end
      end
      MD_BCAST: begin
        if (!lsw_size_ok(size, 2, LSW_LANES) || ({1'b0, bidx} >= size)) begin
          ctl.err = 1'b1;
        end else begin
          ctl.and_m = ~size_m1;
          ctl.or_m  = bidx;
        end
      end
      MD_SWAP: begin
        if (!lsw_size_ok(size, 1, LSW_LANES/2)) ctl.err = 1'b1;
        else ctl.xor_m = size[LSW_IDW-1:0];
      end
      MD_REVERSE: begin
        if (!lsw_size_ok(size, 2, LSW_LANES)) ctl.err = 1'b1;
        else ctl.xor_m = size_m1;
      end
      default: ctl.err = 1'b1;
    endcase
    if (ctl.err) begin
      ctl       = '0;
      ctl.and_m = '1;
      ctl.err   = 1'b1;
    end
  end

endmodule

// File: rtl/lsw_src_gen.sv
module lsw_src_gen
  import lsw_pkg::*;
#(
  parameter int unsigned LANES = LSW_LANES,
  localparam int unsigned IDW  = $clog2(LANES)
)(
  input  lsw_ctl_t              ctl,
  output logic [LANES*IDW-1:0]  src_idx
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign src_idx[i*IDW +: IDW] = lsw_lane_src(ctl, IDW'(i));
  end

endmodule

// File: rtl/lsw_xbar.sv
module lsw_xbar #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDW  = $clog2(LANES)
)(
  input  logic [LANES*DW-1:0]  din,
  input  logic [LANES*IDW-1:0] src_idx,
  output logic [LANES*DW-1:0]  dout
);

  for (genvar i = 0; i < LANES; i++) begin : g_out
    logic [IDW-1:0] sel;
    assign sel = src_idx[i*IDW +: IDW];
    assign dout[i*DW +: DW] = din[sel*DW +: DW];
  end

endmodule

// File: rtl/lsw_unit.sv
module lsw_unit
  import lsw_pkg::*;
#(
  parameter int unsigned LANES = LSW_LANES,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDW  = $clog2(LANES),
  localparam int unsigned BUSW = LANES*DW
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          in_mode,
  input  logic [LSW_PATW-1:0] in_pat,
  input  logic [BUSW-1:0]     in_lanes,
  output logic                out_valid,
  output logic [BUSW-1:0]     out_lanes,
  output logic                out_err
);

  lsw_ctl_t             ctl;
  logic [LANES*IDW-1:0] src_idx;
  logic [BUSW-1:0]      perm_lanes;
  logic                 dec_err;
  logic                 load_en;

  lsw_decode u_dec (
    .mode (in_mode),
    .pat  (in_pat),
    .ctl  (ctl)
  );

  lsw_src_gen #(.LANES(LANES)) u_src (
    .ctl     (ctl),
    .src_idx (src_idx)
  );

  lsw_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
    .din     (in_lanes),
    .src_idx (src_idx),
    .dout    (perm_lanes)
  );

  assign dec_err = ctl.err;
  assign load_en = in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        out_lanes <= perm_lanes;
        out_err   <= dec_err;
      end
    end
  end

endmodule

// File: rtl/lsw_unit_chk.sv
module lsw_unit_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned BUSW = LANES*DW
)(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      in_mode,
  input logic [15:0]     in_pat,
  input logic [BUSW-1:0] in_lanes,
  input logic            out_valid,
  input logic [BUSW-1:0] out_lanes,
  input logic            out_err,
  input logic            dec_err
);

  logic [4:0]    bc_idx;
  logic [DW-1:0] bc_val;
  logic [4:0]    sw_sz;
  logic [DW-1:0] sw_val;
  logic [DW-1:0] rv_val;

  assign bc_idx = in_pat[12:8];
  assign bc_val = in_lanes[bc_idx*DW +: DW];
  assign sw_sz  = in_pat[4:0];
  assign sw_val = in_lanes[sw_sz*DW +: DW];
  assign rv_val = in_lanes[5'(in_pat[5:0] - 6'd1)*DW +: DW];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_lanes) && $stable(out_err)));
  assert_err_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_err) |=> (out_err && out_lanes == $past(in_lanes)));
  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode > 3'd5) |=> out_err);
  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd0) |=> (!out_err && out_lanes == $past(in_lanes)));
  assert_bcast_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd3 && !dec_err) |=> (out_lanes[DW-1:0] == $past(bc_val)));
  assert_swap_lane0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd4 && !dec_err) |=> (out_lanes[DW-1:0] == $past(sw_val)));
  assert_rev_lane0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd5 && !dec_err) |=> (out_lanes[DW-1:0] == $past(rv_val)));

endmodule

bind lsw_unit lsw_unit_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mode   (in_mode),
  .in_pat    (in_pat),
  .in_lanes  (in_lanes),
  .out_valid (out_valid),
  .out_lanes (out_lanes),
  .out_err   (out_err),
  .dec_err   (dec_err)
);

// File: tb/sim_lsw_unit.sv
module sim_lsw_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    in_mode = '0;
  logic [15:0]   in_pat = '0;
  logic [NL*W-1:0] in_lanes = '0;
  logic          out_valid;
  logic [NL*W-1:0] out_lanes;
  logic          out_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsw_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_pat(in_pat), .in_lanes(in_lanes), .out_valid(out_valid),
    .out_lanes(out_lanes), .out_err(out_err)
  );

  function automatic logic [NL*W-1:0] mk_data(input int seed);
    logic [NL*W-1:0] v;
    for (int i = 0; i < NL; i++) v[i*W +: W] = {seed[15:0], 8'(i), 8'(~i)};
    return v;
  endfunction

  function automatic bit is_legal(input int mode, input int pat);
    int sz = pat & 63;
    int ix = (pat >> 8) & 31;
    bit p2 = 0;
    for (int k = 1; k <= 32; k = k * 2) if (sz == k) p2 = 1;
    case (mode)
      0, 1, 2: return 1;
      3: return p2 && sz >= 2 && ix < sz;
      4: return p2 && sz <= 16;
      5: return p2 && sz >= 2;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_src(input int mode, input int pat, input int i);
    int sz = pat & 63;
    int r = 0;
    case (mode)
      1: r = (i / 4) * 4 + ((pat >> (2 * (i % 4))) & 3);
      2: begin
        for (int b = 0; b < 5; b++) begin
          int bit_i = (i >> b) & 1;
          int code = (pat >> (2 * b)) & 3;
          int o = (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? bit_i : 1 - bit_i;
          r = r + (o << b);
        end
      end
      3: r = (i / sz) * sz + ((pat >> 8) & 31);
      4: r = (((i / sz) % 2) == 0) ? i + sz : i - sz;
      5: r = (i / sz) * sz + (sz - 1 - (i % sz));
      default: r = i;
    endcase
    return r;
  endfunction

  function automatic logic [NL*W-1:0] ref_out(input int mode, input int pat,
                                              input logic [NL*W-1:0] d);
    logic [NL*W-1:0] v;
    bit ok = is_legal(mode, pat);
    for (int i = 0; i < NL; i++) begin
      int s = ok ? ref_src(mode, pat, i) : i;
      v[i*W +: W] = d[s*W +: W];
    end
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [NL*W-1:0] act, input logic [NL*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // One command, then a quiet cycle; results checked one cycle after capture.
  task automatic run_cmd(input string req, input int mode, input int pat, input int seed);
    logic [NL*W-1:0] d = mk_data(seed);
    @(negedge clk);
    in_valid = 1'b1; in_mode = 3'(mode); in_pat = 16'(pat); in_lanes = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, $sformatf("lanes mode=%0d pat=%h", mode, pat), out_lanes, ref_out(mode, pat, d));
    check_bit(req, $sformatf("err mode=%0d pat=%h", mode, pat), out_err, !is_legal(mode, pat));
    check_bit("R2", "out_valid after command", out_valid, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R1", "out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "lanes after reset", out_lanes, '0);
    check_bit("R1", "err after reset", out_err, 1'b0);
    check_bit("R1", "valid after reset", out_valid, 1'b0);
  endtask

  task automatic t_pass;
    run_cmd("R4", 0, 16'hFFFF, 1);
    run_cmd("R4", 0, 16'h0000, 2);
  endtask

  task automatic t_quad;
    run_cmd("R5", 1, 16'h001E, 3);
    run_cmd("R5", 1, 16'h00FF, 4);
    run_cmd("R5", 1, 16'hFF1B, 5);
  endtask

  task automatic t_bitmask;
    run_cmd("R6", 2, 16'h006C, 6);
    run_cmd("R6", 2, 16'h03FF, 7);
    run_cmd("R6", 2, 16'h02AA, 8);
    run_cmd("R6", 2, 16'h0155, 9);
  endtask

  task automatic t_bcast;
    run_cmd("R7", 3, (1 << 8) | 2, 10);
    run_cmd("R7", 3, (5 << 8) | 8, 11);
    run_cmd("R7", 3, (31 << 8) | 32, 12);
    run_cmd("R7", 3, (0 << 8) | 16, 13);
  endtask

  task automatic t_swap;
    for (int s = 1; s <= 16; s = s * 2) run_cmd("R8", 4, s, 20 + s);
  endtask

  task automatic t_reverse;
    for (int g = 2; g <= 32; g = g * 2) run_cmd("R9", 5, g, 40 + g);
  endtask

  task automatic t_errors;
    run_cmd("R10", 3, 6, 60);
    run_cmd("R10", 3, (4 << 8) | 4, 61);
    run_cmd("R10", 4, 32, 62);
    run_cmd("R10", 4, 0, 63);
    run_cmd("R10", 5, 1, 64);
    run_cmd("R10", 5, 12, 65);
    run_cmd("R10", 6, 16'h0004, 66);
    run_cmd("R10", 7, 16'h0000, 67);
  endtask

  task automatic t_hold;
    logic [NL*W-1:0] prev;
    run_cmd("R3", 5, 8, 70);
    prev = out_lanes;
    in_mode = 3'd7; in_pat = 16'h1234; in_lanes = mk_data(71);
    repeat (3) @(negedge clk);
    check("R3", "lanes held with in_valid low", out_lanes, prev);
    check_bit("R3", "err held with in_valid low", out_err, 1'b0);
    check_bit("R2", "out_valid low when idle", out_valid, 1'b0);
  endtask

  task automatic t_b2b;
    logic [NL*W-1:0] da = mk_data(80);
    logic [NL*W-1:0] db = mk_data(81);
    @(negedge clk);
    in_valid = 1'b1; in_mode = 3'd4; in_pat = 16'd2; in_lanes = da;
    @(negedge clk);
    check("R2", "first of back-to-back", out_lanes, ref_out(4, 2, da));
    check_bit("R2", "valid first", out_valid, 1'b1);
    in_mode = 3'd3; in_pat = 16'd8; in_lanes = db;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "second of back-to-back", out_lanes, ref_out(3, 8, db));
    check_bit("R2", "valid second", out_valid, 1'b1);
    @(negedge clk);
    check_bit("R2", "valid drops", out_valid, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_quad();
    t_bitmask();
    t_bcast();
    t_swap();
    t_reverse();
    t_errors();
    t_hold();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule